// File: doc/BRIEF.md
# Biphase Lighting-Bus Frame Receiver

This block recovers 16-bit forward frames from a two-wire lighting control bus that carries biphase (Manchester) data at a nominal 1200 bit/s. The receive input `rx_n` is already synchronised to `clk` and is the inverse of the bus level, so a high bus reads as 0. A prescaler turns `clk` into a 1 MHz tick. A width timer counts ticks between input edges. Each interval is classified as one half-bit period (Te), two half-bit periods (2·Te), or illegal.

A phase tracker follows whether the last edge fell on a bit boundary or at mid-bit. From this it rebuilds the start bit and the data bits, which arrive MSB first. The frame ends when the line has been quiet for 4·Te. At that point the block either presents the frame with a one-cycle `frame_valid` strobe or raises a one-cycle `frame_err`. After a frame ends, the block ignores the line for a guard time given by the neighbouring transmitter/controller on `guard_len`, and then arms again.

Top module: `mbr_rx`

## Requirements
- R1: After reset, `frame_valid` and `frame_err` are 0 and `frame_data` is 0.
- R2: A frame starts from idle on a falling bus edge (`rx_n` rising). It is decoded with a mid-bit rising bus edge meaning 1 and a falling bus edge meaning 0. The start bit must be 1. The 16 data bits that follow are placed MSB first into `frame_data[15:0]`.
- R3: An edge interval of TE_MIN..TE_MAX ticks counts as one half-bit. An interval of TE2_MIN..TE2_MAX ticks counts as two half-bits. Frames sent at any half-bit length inside these windows decode correctly.
- R4: An edge interval outside both windows aborts the frame with `frame_err` and no `frame_valid`.
- R5: A two-half-bit interval that begins on a bit boundary aborts the frame with `frame_err`.
- R6: A frame is closed only after STOP_LEN ticks with no edge, with the bus high. `frame_valid` comes STOP_LEN+1 ticks after the last edge, not earlier.
- R7: If the quiet period arrives with fewer than 16 data bits received, the block gives `frame_err` and no `frame_valid`.
- R8: A 17th data bit aborts the frame with `frame_err`.
- R9: For `guard_len` ticks after a frame ends (valid or error), all line activity is ignored. After that, the next frame decodes normally.
- R10: `frame_valid` and `frame_err` are single-cycle pulses that never coincide. `frame_data` changes only in a cycle where `frame_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_n | input | 1 | Synchronised receive input, inverse of bus level |
| guard_len | input | TW | Inter-frame guard length in ticks |
| frame_data | output | DBITS | Last good frame, MSB first on the wire |
| frame_valid | output | 1 | One-cycle strobe for a good frame |
| frame_err | output | 1 | One-cycle strobe for a framing error |

## Verification
The bench builds the block with TICK_DIV=1, so every clock is one tick. It uses windows of 8..12 and 16..24 ticks and STOP_LEN=40, which makes a nominal half-bit 10 clocks. At this scale, frames sent with half-bits of 9, 10 and 11 clocks, pulses of 15 and 20 clocks, and short, long and guard-overlapping frames all fit in a few hundred cycles each. The stop latency can then be checked to the tick.

// File: rtl/mbr_pkg.sv
package mbr_pkg;
   typedef enum logic [1:0] {W_SHORT, W_LONG, W_BAD} wclass_t;
   typedef enum logic [1:0] {S_IDLE, S_RX, S_DRAIN, S_GUARD} rx_state_t;
endpackage

// File: rtl/mbr_tick.sv
module mbr_tick #(
   parameter int TICK_DIV = 50
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   generate
      if (TICK_DIV == 1) begin : g_direct
         assign tick = 1'b1;
      end else begin : g_div
         localparam int DW = $clog2(TICK_DIV);
         logic [DW-1:0] div_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                              div_q <= '0;
            else if (div_q == DW'(TICK_DIV - 1))     div_q <= '0;
            else                                     div_q <= div_q + 1'b1;
         end
         assign tick = (div_q == DW'(TICK_DIV - 1));
      end
   endgenerate
endmodule

// File: rtl/mbr_width.sv
module mbr_width
   import mbr_pkg::*;
#(
   parameter int TW       = 16,
   parameter int TE_MIN   = 333,
   parameter int TE_MAX   = 500,
   parameter int TE2_MIN  = 667,
   parameter int TE2_MAX  = 1000,
   parameter int STOP_LEN = 1668
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          clr,
   input  logic [TW-1:0] guard_len,
   output wclass_t       wcls,
   output logic          quiet,
   output logic          guard_done
);
   localparam logic [TW-1:0] CMAX = '1;
   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     cnt_q <= '0;
      else if (clr)                   cnt_q <= '0;
      else if (tick && cnt_q != CMAX) cnt_q <= cnt_q + 1'b1;
   end

   always_comb begin
      if (cnt_q >= TW'(TE_MIN) && cnt_q <= TW'(TE_MAX))        wcls = W_SHORT;
      else if (cnt_q >= TW'(TE2_MIN) && cnt_q <= TW'(TE2_MAX)) wcls = W_LONG;
      else                                                     wcls = W_BAD;
   end

   assign quiet      = (cnt_q >= TW'(STOP_LEN));
   assign guard_done = (cnt_q >= guard_len);
endmodule

// File: rtl/mbr_decode.sv
module mbr_decode
   import mbr_pkg::*;
#(
   parameter int DBITS = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_n,
   input  wclass_t          wcls,
   input  logic             quiet,
   input  logic             guard_done,
   output logic             clr,
   output logic [DBITS-1:0] frame_data,
   output logic             frame_valid,
   output logic             frame_err
);
   localparam int NB = $clog2(DBITS + 2);
   localparam logic [NB-1:0] FULL = NB'(DBITS + 1);

   rx_state_t        st_q;
   logic             rx_q, at_mid_q;
   logic [NB-1:0]    nbits_q;
   logic [DBITS-1:0] sh_q;
   logic             edge_s, bus_hi;

   assign edge_s = (rx_n != rx_q);
   assign bus_hi = ~rx_n;
   assign clr    = (st_q == S_IDLE) ||
                   ((st_q == S_RX || st_q == S_DRAIN) && (edge_s || quiet));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= S_IDLE;
         rx_q        <= 1'b0;
         at_mid_q    <= 1'b0;
         nbits_q     <= '0;
         sh_q        <= '0;
         frame_data  <= '0;
         frame_valid <= 1'b0;
         frame_err   <= 1'b0;
      end else begin
         rx_q        <= rx_n;
         frame_valid <= 1'b0;
         frame_err   <= 1'b0;
         case (st_q)
            S_IDLE: if (edge_s && rx_n) begin
               st_q     <= S_RX;
               at_mid_q <= 1'b0;
               nbits_q  <= '0;
            end
            S_RX: if (edge_s) begin
               logic emit, bad;
               emit = 1'b0;
               bad  = 1'b0;
               case (wcls)
                  W_SHORT: begin
                     emit     = !at_mid_q;
                     at_mid_q <= !at_mid_q;
                  end
                  W_LONG:  if (at_mid_q) emit = 1'b1; else bad = 1'b1;
                  default: bad = 1'b1;
               endcase
               if (emit) begin
                  if (nbits_q == '0 && !bus_hi) bad = 1'b1;
                  if (nbits_q == FULL)          bad = 1'b1;
                  if (nbits_q != '0)            sh_q <= {sh_q[DBITS-2:0], bus_hi};
                  nbits_q <= nbits_q + 1'b1;
               end
               if (bad) begin
                  frame_err <= 1'b1;
                  st_q      <= S_DRAIN;
               end
            end else if (quiet) begin
               if (nbits_q == FULL && bus_hi) begin
                  frame_valid <= 1'b1;
                  frame_data  <= sh_q;
               end else begin
                  frame_err <= 1'b1;
               end
               st_q <= S_GUARD;
            end
            S_DRAIN: if (!edge_s && quiet) st_q <= S_GUARD;
            S_GUARD: if (guard_done) st_q <= S_IDLE;
            default: st_q <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/mbr_rx.sv
module mbr_rx
   import mbr_pkg::*;
#(
   parameter int TICK_DIV = 50,
   parameter int TW       = 16,
   parameter int DBITS    = 16,
   parameter int TE_MIN   = 333,
   parameter int TE_MAX   = 500,
   parameter int TE2_MIN  = 667,
   parameter int TE2_MAX  = 1000,
   parameter int STOP_LEN = 1668
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_n,
   input  logic [TW-1:0]    guard_len,
   output logic [DBITS-1:0] frame_data,
   output logic             frame_valid,
   output logic             frame_err
);
   generate
      if (!(TICK_DIV > 0 && TE_MIN > 0 && TE_MIN <= TE_MAX && TE_MAX < TE2_MIN &&
            TE2_MIN <= TE2_MAX && TE2_MAX < STOP_LEN && STOP_LEN < 2**TW && DBITS > 1)) begin : g_bad_cfg
         $error("mbr_rx: inconsistent width windows or counter size");
      end
   endgenerate

   logic    tick, clr, quiet, guard_done;
   wclass_t wcls;

   mbr_tick #(.TICK_DIV(TICK_DIV)) u_tick (.clk(clk), .rst_n(rst_n), .tick(tick));

   mbr_width #(.TW(TW), .TE_MIN(TE_MIN), .TE_MAX(TE_MAX), .TE2_MIN(TE2_MIN),
               .TE2_MAX(TE2_MAX), .STOP_LEN(STOP_LEN)) u_width (
      .clk(clk), .rst_n(rst_n), .tick(tick), .clr(clr), .guard_len(guard_len),
      .wcls(wcls), .quiet(quiet), .guard_done(guard_done));

   mbr_decode #(.DBITS(DBITS)) u_dec (
      .clk(clk), .rst_n(rst_n), .rx_n(rx_n), .wcls(wcls), .quiet(quiet),
      .guard_done(guard_done), .clr(clr), .frame_data(frame_data),
      .frame_valid(frame_valid), .frame_err(frame_err));
endmodule

// File: rtl/mbr_rx_chk.sv
module mbr_rx_chk #(
   parameter int TICK_DIV = 50,
   parameter int DBITS    = 16,
   parameter int STOP_LEN = 1668
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rx_n,
   input logic [DBITS-1:0] frame_data,
   input logic             frame_valid,
   input logic             frame_err
);
   localparam int MINQ = (STOP_LEN - 1) * TICK_DIV;
   logic        rx_prev;
   logic [31:0] qcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_prev <= 1'b0;
         qcnt    <= '0;
      end else begin
         rx_prev <= rx_n;
         if (rx_n != rx_prev)  qcnt <= '0;
         else if (~&qcnt)      qcnt <= qcnt + 1'b1;
      end
   end

   AST_VALID_AFTER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      frame_valid |-> (qcnt >= 32'(MINQ))) else $error("early valid"); // R6
   AST_VALID_BUS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      frame_valid |-> !$past(rx_n)) else $error("valid with bus low"); // R6
   AST_NO_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
      !(frame_valid && frame_err)) else $error("valid and err together"); // R10
   AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      frame_valid |=> !frame_valid) else $error("valid held"); // R10
   AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err |=> !frame_err) else $error("err held"); // R10
   AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_valid |-> $stable(frame_data)) else $error("data moved"); // R10
endmodule

bind mbr_rx mbr_rx_chk #(.TICK_DIV(TICK_DIV), .DBITS(DBITS), .STOP_LEN(STOP_LEN)) u_chk (
   .clk(clk), .rst_n(rst_n), .rx_n(rx_n), .frame_data(frame_data),
   .frame_valid(frame_valid), .frame_err(frame_err));

// File: tb/sim_mbr_rx.sv
`timescale 1ns/1ps
module sim_mbr_rx;
   localparam int TW = 12;
   localparam int STOP = 40;
   localparam int NV = 8;
   localparam logic [15:0] VD [NV] = '{16'hA55A, 16'h0000, 16'hFFFF, 16'h8001,
                                       16'h1234, 16'hFE01, 16'h7F80, 16'hC3C3};
   localparam int VTE [NV] = '{10, 10, 10, 9, 11, 9, 11, 10};

   logic          clk = 1'b0, rst_n = 1'b0, rx_n = 1'b0;
   logic [TW-1:0] guard_len = TW'(20);
   logic [15:0]   frame_data;
   logic          frame_valid, frame_err;

   int errors = 0, checks = 0, n_valid = 0, n_err = 0, cyc = 0;
   int valid_cyc = 0, edge_cyc = 0;
   logic [15:0] last_data = '0;
   logic prev_rx = 1'b0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   mbr_rx #(.TICK_DIV(1), .TW(TW), .DBITS(16), .TE_MIN(8), .TE_MAX(12),
            .TE2_MIN(16), .TE2_MAX(24), .STOP_LEN(STOP)) u0 (
      .clk(clk), .rst_n(rst_n), .rx_n(rx_n), .guard_len(guard_len),
      .frame_data(frame_data), .frame_valid(frame_valid), .frame_err(frame_err));

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (frame_valid) begin
         n_valid   <= n_valid + 1;
         last_data <= frame_data;
         valid_cyc <= cyc;
      end
      if (frame_err) n_err <= n_err + 1;
      if (rx_n != prev_rx) edge_cyc <= cyc;
      prev_rx <= rx_n;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic hold(input logic bus, input int n);
      @(posedge clk); #2 rx_n = ~bus;
      repeat (n - 1) @(posedge clk);
   endtask

   task automatic send(input logic [15:0] d, input int te, input int nbits);
      hold(1'b0, te); hold(1'b1, te);
      for (int i = 0; i < nbits; i++) begin
         logic b;
         b = (i < 16) ? d[15 - i] : 1'b0;
         hold(~b, te); hold(b, te);
      end
      @(posedge clk); #2 rx_n = 1'b0;
   endtask

   task automatic finish_up();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (200000 - 10000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
         finish_up();
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(frame_valid == 0, "R1 valid", frame_valid, 0);
      chk(frame_err == 0, "R1 err", frame_err, 0);
      chk(frame_data == 0, "R1 data", frame_data, 0);
      rst_n = 1'b1;
      repeat (5) @(posedge clk);

      // R2 R3: table of frames at several half-bit lengths
      for (int k = 0; k < NV; k++) begin
         int v0, e0;
         v0 = n_valid; e0 = n_err;
         send(VD[k], VTE[k], 16);
         repeat (120) @(posedge clk);
         @(negedge clk);
         chk(n_valid == v0 + 1 && n_err == e0, "R3 frame accepted", n_valid - v0, 1);
         chk(last_data == VD[k], "R2 data", last_data, VD[k]);
      end

      // R6: stop latency measured from the last edge
      begin
         send(16'h5A5A, 10, 16);
         repeat (120) @(posedge clk);
         @(negedge clk);
         chk(valid_cyc - edge_cyc >= STOP + 1 && valid_cyc - edge_cyc <= STOP + 3,
             "R6 latency", valid_cyc - edge_cyc, STOP + 2);
      end

      // R4: pulse between the windows
      begin
         int v0, e0;
         v0 = n_valid; e0 = n_err;
         hold(1'b0, 15); @(posedge clk); #2 rx_n = 1'b0;
         repeat (150) @(posedge clk); @(negedge clk);
         chk(n_err == e0 + 1 && n_valid == v0, "R4 bad width", n_err - e0, 1);
      end

      // R5: long pulse from a bit boundary
      begin
         int v0, e0;
         v0 = n_valid; e0 = n_err;
         hold(1'b0, 20); @(posedge clk); #2 rx_n = 1'b0;
         repeat (150) @(posedge clk); @(negedge clk);
         chk(n_err == e0 + 1 && n_valid == v0, "R5 long at boundary", n_err - e0, 1);
      end

      // R7: only 15 data bits
      begin
         int v0, e0;
         v0 = n_valid; e0 = n_err;
         send(16'hFFFF, 10, 15);
         repeat (150) @(posedge clk); @(negedge clk);
         chk(n_err == e0 + 1 && n_valid == v0, "R7 short frame", n_err - e0, 1);
      end

      // R8: 17 data bits
      begin
         int v0, e0;
         v0 = n_valid; e0 = n_err;
         send(16'h0F0F, 10, 17);
         repeat (150) @(posedge clk); @(negedge clk);
         chk(n_err == e0 + 1 && n_valid == v0, "R8 long frame", n_err - e0, 1);
         chk(last_data == 16'h5A5A, "R10 data held after errors", last_data, 16'h5A5A);
      end

      // R9: frame inside the guard is ignored, next one decodes
      begin
         int v0, e0;
         guard_len = TW'(600);
         v0 = n_valid; e0 = n_err;
         send(16'h1111, 10, 16);
         while (n_valid == v0) @(negedge clk);
         send(16'h2222, 10, 16);
         repeat (400) @(posedge clk); @(negedge clk);
         chk(n_valid == v0 + 1 && n_err == e0, "R9 ignored in guard", n_valid - v0, 1);
         chk(last_data == 16'h1111, "R9 data kept", last_data, 16'h1111);
         send(16'h3333, 10, 16);
         repeat (700) @(posedge clk); @(negedge clk);
         chk(n_valid == v0 + 2 && last_data == 16'h3333, "R9 rearmed", last_data, 16'h3333);
      end

      done = 1'b1;
      finish_up();
   end
endmodule